// File: doc/BRIEF.md
# Indirect Register-Window Bus Bridge

This block gives a host, which sees only a few registers, read and write access to a separate internal bus with 32-bit addresses and 32-bit data. To write, the host loads a target address register and a write-data register in either order. The bridge starts the internal bus write only once both registers hold fresh values. To read, the host loads the target address and then reads the read-data register. The bridge holds back the answer to that host read until the internal bus returns data.

On the internal bus, a request is held until the target raises an acknowledge. A cycle counter limits how long the bridge waits. If no target answers within the window, the bridge drops the request and records a sticky error. A timed-out read returns the marker word 0xABCDABCD instead of data. A control register shows a busy flag and the sticky error flag, and the host clears the error by writing a one to it.

Top module: `ibus_bridge`

## Requirements
- R1: After reset, bus_req and hst_rvalid are 0, and a read of the control register at offset 0x244 returns 0.
- R2: A read of offset 0x240 returns the last value written to the address register. A read of offset 0x248 returns the last value written to the write-data register. A read of any offset not in the map returns 0.
- R3: A bus write (bus_req=1, bus_we=1) starts in the cycle after the second of the two writes (address register and write-data register), in either order. A write to only one of them starts nothing.
- R4: The bus write carries the address register value on bus_addr and the write-data value on bus_wdata. Both "written" flags clear when the write starts, so the next bus write again needs both registers written.
- R5: A host read of offset 0x250 starts a bus read (bus_we=0) at the address register value. hst_rvalid stays low until the bus finishes. A read answered by an acknowledge returns bus_rdata, captured on the acknowledge cycle.
- R6: While bus_req is high without bus_ack, bus_req, bus_we, bus_addr and bus_wdata stay stable. bus_req is low in the cycle after bus_ack.
- R7: If no acknowledge arrives within TIMEOUT (default 256) request cycles, bus_req drops and error flag bit 1 of the control register is set. A timed-out read returns 0xABCDABCD.
- R8: An acknowledge in the last cycle of the window (request cycle TIMEOUT-1, counting from 0) is accepted as a normal completion, with no error.
- R9: Control register bit 0 reads 1 while a bus transfer is running. Bit 1 is the sticky error flag. Writing 1 to bit 1 clears it, and writing 0 to it leaves it unchanged.
- R10: While a bus transfer is running, host writes to any register are ignored and leave the register contents unchanged.
- R11: Reads of offsets other than 0x250 answer with hst_rvalid=1 in the cycle after the read is sampled. During a bus write these reads are still served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hst_wr | input | 1 | Host write strobe, one cycle per access |
| hst_rd | input | 1 | Host read strobe, one cycle per access (ignored when hst_wr is high) |
| hst_addr | input | OFFW (12) | Host register byte offset |
| hst_wdata | input | DW (32) | Host write data |
| hst_rdata | output | DW (32) | Host read data, valid with hst_rvalid |
| hst_rvalid | output | 1 | One-cycle read response strobe |
| bus_req | output | 1 | Internal bus request, held until acknowledge or timeout |
| bus_we | output | 1 | 1 = write transfer, 0 = read transfer |
| bus_addr | output | AW (32) | Internal bus address |
| bus_wdata | output | DW (32) | Internal bus write data |
| bus_ack | input | 1 | Target acknowledge, one cycle |
| bus_rdata | input | DW (32) | Target read data, valid with bus_ack |

## Verification
The acknowledge and the timeout expiry can land in the same cycle, when the target answers in the very last request cycle of the window. The bench provokes this with a target whose answer delay is set to exactly TIMEOUT-1 cycles, and then to TIMEOUT cycles. In the first case it expects the real data and a clear error flag. In the second it expects the marker word and a set error flag. The bench also lets the second register write and the arming of a transfer coincide, and checks that the bus request rises in the very next cycle with the just-written value on the bus.

// File: rtl/ibb_pkg.sv
package ibb_pkg;

  // Register window byte offsets (host-visible map)
  localparam int OFF_TADDR = 'h240;
  localparam int OFF_CTRL  = 'h244;
  localparam int OFF_TDATA = 'h248;
  localparam int OFF_RDATA = 'h250;

  // Control register bit positions
  localparam int CTRL_BUSY_BIT = 0;
  localparam int CTRL_ERR_BIT  = 1;

  // Marker returned for a read nobody answered
  localparam logic [31:0] NO_RESP_WORD = 32'hABCD_ABCD;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_WRITE = 2'd1,
    XF_READ  = 2'd2
  } xfer_state_e;

endpackage

// File: rtl/ibb_timer.sv
module ibb_timer #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q != CW'(LIMIT - 1)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Last permitted request cycle is LIMIT-1 (counting from 0)
  assign expired = run && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/ibb_bus_fsm.sv
module ibb_bus_fsm
  import ibb_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int TIMEOUT = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_wr,
  input  logic          start_rd,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          rd_inflight,
  output logic          done,
  output logic          done_err,
  output logic          done_rd,
  output logic [DW-1:0] rdata_out
);

  xfer_state_e state_q;
  logic        expired;

  ibb_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (busy),
    .expired(expired)
  );

  assign busy        = (state_q != XF_IDLE);
  assign rd_inflight = (state_q == XF_READ);
  // An acknowledge wins over expiry in the same cycle
  assign done        = busy && (bus_ack || expired);
  assign done_err    = busy && !bus_ack && expired;
  assign done_rd     = rd_inflight;
  assign rdata_out   = bus_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= XF_IDLE;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      case (state_q)
        XF_IDLE: begin
          if (start_wr) begin
            state_q   <= XF_WRITE;
            bus_req   <= 1'b1;
            bus_we    <= 1'b1;
            bus_addr  <= addr_in;
            bus_wdata <= wdata_in;
          end else if (start_rd) begin
            state_q  <= XF_READ;
            bus_req  <= 1'b1;
            bus_we   <= 1'b0;
            bus_addr <= addr_in;
          end
        end
        default: begin
          if (done) begin
            state_q <= XF_IDLE;
            bus_req <= 1'b0;
            bus_we  <= 1'b0;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/ibb_regs.sv
module ibb_regs
  import ibb_pkg::*;
#(
  parameter int OFFW = 12,
  parameter int AW   = 32,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hst_wr,
  input  logic            hst_rd,
  input  logic [OFFW-1:0] hst_addr,
  input  logic [DW-1:0]   hst_wdata,
  output logic [DW-1:0]   hst_rdata,
  output logic            hst_rvalid,
  input  logic            busy,
  input  logic            rd_inflight,
  input  logic            done,
  input  logic            done_err,
  input  logic            done_rd,
  input  logic [DW-1:0]   bus_rdata_in,
  output logic            start_wr,
  output logic            start_rd,
  output logic [AW-1:0]   tgt_addr,
  output logic [DW-1:0]   tgt_wdata
);

  localparam logic [DW-1:0] ERR_WORD = DW'(NO_RESP_WORD);

  logic          idle;
  logic          acc_wr, acc_rd;
  logic          hit_taddr, hit_tdata, hit_ctrl, hit_rdata;
  logic          wr_taddr, wr_tdata, wr_ctrl;
  logic          taddr_seen_q, tdata_seen_q;
  logic [AW-1:0] taddr_q;
  logic [DW-1:0] tdata_q;
  logic          err_q;
  logic [DW-1:0] ctrl_word;
  logic [DW-1:0] reg_mux;
  logic          plain_rd;

  assign idle   = !busy;
  assign acc_wr = hst_wr && idle;
  assign acc_rd = hst_rd && !hst_wr;

  assign hit_taddr = (hst_addr == OFFW'(OFF_TADDR));
  assign hit_tdata = (hst_addr == OFFW'(OFF_TDATA));
  assign hit_ctrl  = (hst_addr == OFFW'(OFF_CTRL));
  assign hit_rdata = (hst_addr == OFFW'(OFF_RDATA));

  assign wr_taddr = acc_wr && hit_taddr;
  assign wr_tdata = acc_wr && hit_tdata;
  assign wr_ctrl  = acc_wr && hit_ctrl;

  // Arm when both halves are fresh, counting a write landing this cycle
  assign start_wr = idle && (taddr_seen_q || wr_taddr) && (tdata_seen_q || wr_tdata);
  assign start_rd = idle && acc_rd && hit_rdata;

  // Bypass so the bus sees a value written in the arming cycle
  assign tgt_addr  = wr_taddr ? AW'(hst_wdata) : taddr_q;
  assign tgt_wdata = wr_tdata ? hst_wdata : tdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      taddr_q      <= '0;
      tdata_q      <= '0;
      taddr_seen_q <= 1'b0;
      tdata_seen_q <= 1'b0;
    end else begin
      if (wr_taddr) taddr_q <= AW'(hst_wdata);
      if (wr_tdata) tdata_q <= hst_wdata;
      if (start_wr) begin
        taddr_seen_q <= 1'b0;
        tdata_seen_q <= 1'b0;
      end else begin
        if (wr_taddr) taddr_seen_q <= 1'b1;
        if (wr_tdata) tdata_seen_q <= 1'b1;
      end
    end
  end

  // Sticky error: set by a timeout, cleared by writing one to its bit.
  // Host writes are blocked while busy, so set and clear never coincide.
  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
    end else if (done_err) begin
      err_q <= 1'b1;
    end else if (wr_ctrl && hst_wdata[CTRL_ERR_BIT]) begin
      err_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[CTRL_BUSY_BIT] = busy;
    ctrl_word[CTRL_ERR_BIT]  = err_q;
  end

  always_comb begin
    reg_mux = '0;
    if (hit_taddr)      reg_mux = DW'(taddr_q);
    else if (hit_tdata) reg_mux = tdata_q;
    else if (hit_ctrl)  reg_mux = ctrl_word;
  end

  // Plain register reads are held off only during a bus read, whose
  // completion owns the response slot.
  assign plain_rd = acc_rd && !hit_rdata && !rd_inflight;

  always_ff @(posedge clk) begin
    if (rst) begin
      hst_rvalid <= 1'b0;
      hst_rdata  <= '0;
    end else begin
      hst_rvalid <= 1'b0;
      if (done && done_rd) begin
        hst_rvalid <= 1'b1;
        hst_rdata  <= done_err ? ERR_WORD : bus_rdata_in;
      end else if (plain_rd) begin
        hst_rvalid <= 1'b1;
        hst_rdata  <= reg_mux;
      end
    end
  end

endmodule

// File: rtl/ibus_bridge.sv
module ibus_bridge
  import ibb_pkg::*;
#(
  parameter int OFFW    = 12,
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int TIMEOUT = 256
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hst_wr,
  input  logic            hst_rd,
  input  logic [OFFW-1:0] hst_addr,
  input  logic [DW-1:0]   hst_wdata,
  output logic [DW-1:0]   hst_rdata,
  output logic            hst_rvalid,
  output logic            bus_req,
  output logic            bus_we,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  input  logic            bus_ack,
  input  logic [DW-1:0]   bus_rdata
);

  logic          start_wr, start_rd;
  logic [AW-1:0] tgt_addr;
  logic [DW-1:0] tgt_wdata;
  logic          busy, rd_inflight;
  logic          done, done_err, done_rd;
  logic [DW-1:0] rdata_fwd;

  ibb_regs #(.OFFW(OFFW), .AW(AW), .DW(DW)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .hst_wr      (hst_wr),
    .hst_rd      (hst_rd),
    .hst_addr    (hst_addr),
    .hst_wdata   (hst_wdata),
    .hst_rdata   (hst_rdata),
    .hst_rvalid  (hst_rvalid),
    .busy        (busy),
    .rd_inflight (rd_inflight),
    .done        (done),
    .done_err    (done_err),
    .done_rd     (done_rd),
    .bus_rdata_in(rdata_fwd),
    .start_wr    (start_wr),
    .start_rd    (start_rd),
    .tgt_addr    (tgt_addr),
    .tgt_wdata   (tgt_wdata)
  );

  ibb_bus_fsm #(.AW(AW), .DW(DW), .TIMEOUT(TIMEOUT)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_wr   (start_wr),
    .start_rd   (start_rd),
    .addr_in    (tgt_addr),
    .wdata_in   (tgt_wdata),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack),
    .bus_rdata  (bus_rdata),
    .busy       (busy),
    .rd_inflight(rd_inflight),
    .done       (done),
    .done_err   (done_err),
    .done_rd    (done_rd),
    .rdata_out  (rdata_fwd)
  );

endmodule

// File: rtl/ibus_bridge_chk.sv
module ibus_bridge_chk
  import ibb_pkg::*;
#(
  parameter int OFFW    = 12,
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int TIMEOUT = 256
) (
  input logic            clk,
  input logic            rst,
  input logic            hst_wr,
  input logic            hst_rd,
  input logic [OFFW-1:0] hst_addr,
  input logic [DW-1:0]   hst_rdata,
  input logic            hst_rvalid,
  input logic            bus_req,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            bus_ack,
  input logic [DW-1:0]   bus_rdata
);

  localparam int CW = $clog2(TIMEOUT) + 1;

  // Independent count of request cycles, 0 in the first one
  logic [CW-1:0] rq_cnt;
  always_ff @(posedge clk) begin
    if (rst || !bus_req) rq_cnt <= '0;
    else                 rq_cnt <= rq_cnt + 1'b1;
  end

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack && rq_cnt < CW'(TIMEOUT - 1)) |=>
      (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

  assert_ack_release_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ack) |=> !bus_req);

  assert_window_end_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_req && rq_cnt == CW'(TIMEOUT - 1)) |=> !bus_req);

  assert_marker_word_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_req) && !$past(bus_ack) && !$past(bus_we)) |->
      (hst_rvalid && hst_rdata == DW'(NO_RESP_WORD)));

  assert_read_data_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_req) && $past(bus_ack) && !$past(bus_we)) |->
      (hst_rvalid && hst_rdata == $past(bus_rdata)));

  assert_write_arm_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req) && bus_we) |->
      $past(hst_wr && (hst_addr == OFFW'(OFF_TADDR) || hst_addr == OFFW'(OFF_TDATA))));

  assert_read_launch_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req) && !bus_we) |->
      $past(hst_rd && !hst_wr && hst_addr == OFFW'(OFF_RDATA)));

endmodule

bind ibus_bridge ibus_bridge_chk #(
  .OFFW(OFFW), .AW(AW), .DW(DW), .TIMEOUT(TIMEOUT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hst_wr    (hst_wr),
  .hst_rd    (hst_rd),
  .hst_addr  (hst_addr),
  .hst_rdata (hst_rdata),
  .hst_rvalid(hst_rvalid),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_ack   (bus_ack),
  .bus_rdata (bus_rdata)
);

// File: tb/ibus_bridge_tb.sv
module ibus_bridge_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 256;
  localparam logic [11:0] A_TADDR = 12'h240;
  localparam logic [11:0] A_CTRL  = 12'h244;
  localparam logic [11:0] A_TDATA = 12'h248;
  localparam logic [11:0] A_RDATA = 12'h250;
  localparam logic [31:0] MARK    = 32'hABCDABCD;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_wr = 1'b0, hst_rd = 1'b0;
  logic [11:0] hst_addr = '0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        hst_rvalid;
  logic        bus_req, bus_we, bus_ack = 1'b0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;

  int errors = 0;
  int checks = 0;

  ibus_bridge #(.TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst(rst),
    .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- target model ----------------
  logic [31:0] tgt_mem [16];
  logic [31:0] ref_mem [16];
  int          resp_delay = 0;
  int          wr_count = 0;
  int          unstable = 0;
  logic [31:0] last_waddr = '0;
  int          rcnt = 0;
  bit          fired = 0;
  logic [31:0] held_addr = '0;

  always @(negedge clk) begin
    bus_ack = 1'b0;
    if (!bus_req) begin
      rcnt  = 0;
      fired = 0;
    end else begin
      if (rcnt > 0 && bus_addr != held_addr) unstable++;
      held_addr = bus_addr;
      if (!fired && !bus_addr[31]) begin
        if (rcnt == resp_delay) begin
          bus_ack = 1'b1;
          fired   = 1;
          if (bus_we) begin
            tgt_mem[bus_addr[5:2]] = bus_wdata;
            wr_count++;
            last_waddr = bus_addr;
          end else begin
            bus_rdata = tgt_mem[bus_addr[5:2]];
          end
        end
      end
      rcnt++;
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [31:0] exp_read(input logic [31:0] a);
    return a[31] ? MARK : ref_mem[a[5:2]];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [11:0] off, input logic [31:0] d);
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = off; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  // lat returns the number of extra negedges waited after the first one
  task automatic host_read(input logic [11:0] off, output logic [31:0] d,
                           output int lat);
    int n;
    @(negedge clk);
    hst_rd = 1'b1; hst_addr = off;
    @(negedge clk);
    hst_rd = 1'b0;
    n = 0;
    while (!hst_rvalid && n < 2000) begin
      @(negedge clk);
      n++;
    end
    d   = hst_rvalid ? hst_rdata : 32'hDEAD_0000;
    lat = n;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    int l;
    for (int i = 0; i < 1000; i++) begin
      host_read(A_CTRL, c, l);
      if (c[0] == 1'b0) break;
    end
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    host_write(A_TADDR, a);
    host_write(A_TDATA, d);
    if (!a[31]) ref_mem[a[5:2]] = d;
    wait_idle();
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] d);
    int l;
    host_write(A_TADDR, a);
    host_read(A_RDATA, d, l);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] rd, a, d;
    int lat, wc0;
    void'($urandom(32'd20240613));
    for (int i = 0; i < 16; i++) begin
      tgt_mem[i] = 32'h1000_0000 + 32'(i);
      ref_mem[i] = 32'h1000_0000 + 32'(i);
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(bus_req == 1'b0, "R1 bus_req", 32'(bus_req), 0);
    check(hst_rvalid == 1'b0, "R1 rvalid", 32'(hst_rvalid), 0);
    host_read(A_CTRL, rd, lat);
    check(rd == 0, "R1 ctrl", rd, 0);

    // R2 readback and unmapped
    host_write(A_TADDR, 32'h0000_0014);
    host_read(A_TADDR, rd, lat);
    check(rd == 32'h14, "R2 addr readback", rd, 32'h14);
    host_write(A_TDATA, 32'hCAFE_F00D);
    // both written now -> a write to index 5 was issued
    ref_mem[5] = 32'hCAFE_F00D;
    wait_idle();
    host_read(A_TDATA, rd, lat);
    check(rd == 32'hCAFE_F00D, "R2 wdata readback", rd, 32'hCAFE_F00D);
    host_read(12'h100, rd, lat);
    check(rd == 0, "R2 unmapped", rd, 0);
    // R11 plain read answers with no extra wait
    check(lat == 0, "R11 plain read latency", 32'(lat), 0);

    // R3 only address written: nothing starts
    wc0 = wr_count;
    host_write(A_TADDR, 32'h0000_0008);
    repeat (10) @(negedge clk);
    check(wr_count == wc0 && !bus_req, "R3 addr only", 32'(wr_count), 32'(wc0));
    // second write: request must be up at the very next negedge
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = A_TDATA; hst_wdata = 32'h1234_5678;
    @(negedge clk);
    hst_wr = 1'b0;
    check(bus_req && bus_we, "R3 arm next cycle", 32'(bus_req), 1);
    check(bus_addr == 32'h8 && bus_wdata == 32'h1234_5678, "R4 bus fields",
          bus_wdata, 32'h1234_5678);
    ref_mem[2] = 32'h1234_5678;
    wait_idle();
    check(last_waddr == 32'h8, "R4 write address", last_waddr, 32'h8);

    // R3 reverse order, and R4 flags cleared
    wc0 = wr_count;
    host_write(A_TDATA, 32'h5555_AAAA);
    repeat (10) @(negedge clk);
    check(wr_count == wc0, "R4 flags cleared", 32'(wr_count), 32'(wc0));
    host_write(A_TADDR, 32'h0000_000C);
    ref_mem[3] = 32'h5555_AAAA;
    wait_idle();
    check(wr_count == wc0 + 1 && tgt_mem[3] == 32'h5555_AAAA, "R3 data then addr",
          tgt_mem[3], 32'h5555_AAAA);

    // R5 read back through the bus
    resp_delay = 7;
    do_read(32'h0000_000C, rd);
    check(rd == 32'h5555_AAAA, "R5 bus read", rd, 32'h5555_AAAA);

    // R9 busy bit, R10 writes ignored while busy
    resp_delay = 40;
    host_write(A_TADDR, 32'h0000_0010);
    host_write(A_TDATA, 32'h0BAD_BEEF);
    ref_mem[4] = 32'h0BAD_BEEF;
    host_read(A_CTRL, rd, lat);
    check(rd[0] == 1'b1, "R9 busy set", rd, 1);
    check(lat == 0, "R11 read during bus write", 32'(lat), 0);
    host_write(A_TADDR, 32'h0000_0030);
    wait_idle();
    host_read(A_TADDR, rd, lat);
    check(rd == 32'h10, "R10 write ignored", rd, 32'h10);

    // R7 read timeout -> marker and sticky error
    resp_delay = 0;
    do_read(32'h8000_0004, rd);
    check(rd == MARK, "R7 marker word", rd, MARK);
    host_read(A_CTRL, rd, lat);
    check(rd == 32'h2, "R7 error set", rd, 32'h2);
    host_write(A_CTRL, 32'h0);
    host_read(A_CTRL, rd, lat);
    check(rd == 32'h2, "R9 write zero keeps", rd, 32'h2);
    host_write(A_CTRL, 32'h2);
    host_read(A_CTRL, rd, lat);
    check(rd == 32'h0, "R9 write one clears", rd, 32'h0);

    // R7 write timeout sets error, no target write
    wc0 = wr_count;
    do_write(32'h8000_0000, 32'h7777_7777);
    host_read(A_CTRL, rd, lat);
    check(rd == 32'h2 && wr_count == wc0, "R7 write timeout", rd, 32'h2);
    host_write(A_CTRL, 32'h2);

    // R8 acknowledge on the final window cycle wins
    resp_delay = TMO - 1;
    do_read(32'h0000_0010, rd);
    check(rd == 32'h0BAD_BEEF, "R8 last-cycle ack data", rd, 32'h0BAD_BEEF);
    host_read(A_CTRL, rd, lat);
    check(rd == 32'h0, "R8 no error", rd, 32'h0);
    resp_delay = TMO;
    do_read(32'h0000_0010, rd);
    check(rd == MARK, "R8 one cycle late", rd, MARK);
    host_read(A_CTRL, rd, lat);
    check(rd == 32'h2, "R8 late sets error", rd, 32'h2);
    host_write(A_CTRL, 32'h2);

    // Random mix
    for (int k = 0; k < 150; k++) begin
      resp_delay = int'($urandom_range(0, 5));
      a = {($urandom_range(0, 7) == 0), 25'd0, 4'($urandom_range(0, 15)), 2'b00};
      if ($urandom_range(0, 1) == 1) begin
        d = $urandom();
        do_write(a, d);
      end else begin
        do_read(a, rd);
        check(rd == exp_read(a), "R5 random read", rd, exp_read(a));
      end
    end
    host_read(A_CTRL, rd, lat);
    check(rd[0] == 1'b0, "R9 idle after mix", rd, 0);

    check(unstable == 0, "R6 address held", 32'(unstable), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule